// File: doc/BRIEF.md
# Serial Byte Memory Slave

This block is the slave end of a four-wire serial bus in front of a byte-wide storage array. A host selects it with an active-low select line, shifts in a one-byte command, a sixteen-bit address where the command needs one, and then data. Data moves most significant bit first. Reads return array bytes, or the status byte, on the serial output. The address counter advances after every data byte, so one frame can stream through any number of bytes. A write takes effect at the end of its eighth bit and needs no busy time.

The serial pins are brought onto the system clock through a short synchronizer chain, and their edges are detected there. Input bits are taken on rising serial-clock edges. Output bits change on falling edges. This makes clock-idle-low (mode 0) and clock-idle-high (mode 3) hosts work with no setting. The serial clock must run at no more than about one sixth of the system clock. A pause input freezes a frame in the middle, and a write-protect pin can lock the status byte. The array depth is 2**ADDR_W bytes. The default is 10 bits, to keep elaboration small. A full 32,768-byte part sets ADDR_W to 15. The bus carries no flow control, so the block has no valid/ready handshake. The host paces every bit.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the status byte reads 0x00 and `spi_so_oe` is low.
- R2: Command 0x03 (read) and command 0x02 (write) each take two address bytes, high byte first. Address bits at and above ADDR_W are ignored. Written bytes read back unchanged, MSB first, with either serial-clock idle level.
- R3: The address counter moves up by one after every data byte and wraps from 2**ADDR_W-1 to 0.
- R4: Command 0x06 sets the write-enable flag and command 0x04 clears it. A data byte sent while the flag is clear leaves the array unchanged.
- R5: When select is released after a write frame with at least one whole data byte, or after a whole status-write byte (command 0x01), the write-enable flag clears.
- R6: Status bits [3:2] protect part of the array against writes: 01 guards the top quarter, 10 guards the top half and 11 guards all of it. Bytes aimed at a guarded address are dropped, and the address still advances.
- R7: Status bit 7 arms the protect pin. With bit 7 set and `spi_wp_n` low, a status write changes nothing. Otherwise it loads bits 7 and 3:2.
- R8: While selected with `spi_hold_n` low, serial-clock edges and input data are ignored and `spi_so_oe` is low. The bit position and the frame resume unchanged once hold is released.
- R9: While `spi_cs_n` is high, all other inputs are ignored. On release a partial byte is discarded and the frame restarts at the command byte. A final rising edge that arrives in the same sampled cycle as the release counts as part of the partial byte.
- R10: An unknown command makes the rest of the frame void until select is released.
- R11: Command 0x05 returns the status byte {bit7 pin-arm, 000, bits 3:2 protect, bit1 write-enable, bit0 0}, repeated for as long as the host clocks.
- R12: No busy period exists. Bit 0 of the status byte is always 0, and a read frame straight after a write frame returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low select |
| spi_hold_n | input | 1 | Active-low pause |
| spi_wp_n | input | 1 | Active-low status write protect |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for `spi_so`; the pad is high-impedance when low |

## Verification
Select release and the last rising clock edge of a byte pass through the same synchronizer chain. They can therefore surface in the same system-clock cycle. The bench provokes this by raising select and the serial clock in the same time step on the eighth bit of a write data byte. The design is judged right if that array byte stays unchanged and the status byte still shows write-enable set, because no data byte was ever completed. The random section mixes frames in both clock modes with and without write enable, and compares every read against a model held in the bench.

// File: rtl/smem_pkg.sv
package smem_pkg;

  typedef enum logic [7:0] {
    CMD_WEN_SET  = 8'h06,
    CMD_WEN_CLR  = 8'h04,
    CMD_SR_READ  = 8'h05,
    CMD_SR_WRITE = 8'h01,
    CMD_READ     = 8'h03,
    CMD_WRITE    = 8'h02
  } smem_cmd_e;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADR_HI,
    PH_ADR_LO,
    PH_RD_DATA,
    PH_WR_DATA,
    PH_SR_OUT,
    PH_SR_IN,
    PH_VOID
  } smem_phase_e;

  // guard decision from the two top address bits and the protect field
  function automatic logic guarded(input logic [1:0] top2, input logic [1:0] prot);
    logic g;
    case (prot)
      2'b01:   g = (top2 == 2'b11);
      2'b10:   g = top2[1];
      2'b11:   g = 1'b1;
      default: g = 1'b0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/smem_pin_sync.sv
module smem_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  input  logic wp_n,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_sel,
  output logic cs_rise,
  output logic hold_ok,
  output logic wp_ok,
  output logic si_s
);
  localparam int NPIN = 5;
  // idle values: {si, wp_n, hold_n, cs_n, sck}
  localparam logic [NPIN-1:0] IDLE_VEC = 5'b01110;

  logic [NPIN-1:0]             raw;
  logic [STAGES-1:0][NPIN-1:0] chain;
  logic [NPIN-1:0]             cur;
  logic [1:0]                  prev;

  assign raw = {si, wp_n, hold_n, cs_n, sck};
  assign cur = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{IDLE_VEC}};
      prev  <= IDLE_VEC[1:0];
    end else begin
      chain <= {chain[STAGES-2:0], raw};
      prev  <= cur[1:0];
    end
  end

  assign sck_rise = cur[0] & ~prev[0];
  assign sck_fall = ~cur[0] & prev[0];
  assign cs_sel   = ~cur[1];
  assign cs_rise  = cur[1] & ~prev[1];
  assign hold_ok  = cur[2];
  assign wp_ok    = cur[3];
  assign si_s     = cur[4];

endmodule

// File: rtl/smem_array.sv
module smem_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/smem_ctrl.sv
module smem_ctrl
  import smem_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_sel,
  input  logic              cs_rise,
  input  logic              hold_ok,
  input  logic              wp_ok,
  input  logic              si_s,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              so,
  output logic              so_oe
);
  logic              active, rx_edge, tx_edge, byte_done;
  logic [2:0]        bit_q;
  logic [6:0]        rx_q;
  logic [7:0]        byte_in;
  smem_phase_e       phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        hi_q;
  logic [15:0]       full_addr;
  logic              is_wr_q;
  logic              wel_q, wpen_q, clr_pend_q;
  logic [1:0]        bp_q;
  logic [7:0]        tx_next_q, tx_sh_q;
  logic              tx_load_q;
  logic [7:0]        status_byte;
  logic              sr_locked, addr_guarded;
  logic              unused_hi;

  assign active      = cs_sel & hold_ok;
  assign rx_edge     = active & sck_rise;
  assign tx_edge     = active & sck_fall;
  assign byte_in     = {rx_q, si_s};
  assign byte_done   = rx_edge & (bit_q == 3'd7);
  assign full_addr   = {hi_q, byte_in};
  assign unused_hi   = ^full_addr[15:ADDR_W];
  assign status_byte = {wpen_q, 3'b000, bp_q, wel_q, 1'b0};
  assign sr_locked   = wpen_q & ~wp_ok;
  assign addr_guarded = guarded(addr_q[ADDR_W-1 -: 2], bp_q);

  assign mem_raddr = (phase_q == PH_ADR_LO) ? full_addr[ADDR_W-1:0] : addr_q;
  assign mem_waddr = addr_q;
  assign mem_wdata = byte_in;
  assign mem_we    = byte_done & (phase_q == PH_WR_DATA) & wel_q & ~addr_guarded;

  assign so    = tx_sh_q[7];
  assign so_oe = active & ((phase_q == PH_RD_DATA) | (phase_q == PH_SR_OUT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q      <= '0;
      rx_q       <= '0;
      phase_q    <= PH_CMD;
      addr_q     <= '0;
      hi_q       <= '0;
      is_wr_q    <= 1'b0;
      wel_q      <= 1'b0;
      wpen_q     <= 1'b0;
      bp_q       <= 2'b00;
      clr_pend_q <= 1'b0;
      tx_next_q  <= '0;
      tx_load_q  <= 1'b0;
      tx_sh_q    <= '0;
    end else if (cs_rise) begin
      bit_q      <= '0;
      phase_q    <= PH_CMD;
      tx_load_q  <= 1'b0;
      clr_pend_q <= 1'b0;
      if (clr_pend_q) wel_q <= 1'b0;
    end else begin
      if (rx_edge) begin
        bit_q <= bit_q + 3'd1;
        rx_q  <= byte_in[6:0];
      end
      if (byte_done) begin
        case (phase_q)
          PH_CMD: begin
            case (byte_in)
              CMD_WEN_SET:  begin wel_q <= 1'b1; phase_q <= PH_VOID; end
              CMD_WEN_CLR:  begin wel_q <= 1'b0; phase_q <= PH_VOID; end
              CMD_SR_READ:  begin
                tx_next_q <= status_byte;
                tx_load_q <= 1'b1;
                phase_q   <= PH_SR_OUT;
              end
              CMD_SR_WRITE: phase_q <= PH_SR_IN;
              CMD_READ:     begin is_wr_q <= 1'b0; phase_q <= PH_ADR_HI; end
              CMD_WRITE:    begin is_wr_q <= 1'b1; phase_q <= PH_ADR_HI; end
              default:      phase_q <= PH_VOID;
            endcase
          end
          PH_ADR_HI: begin
            hi_q    <= byte_in;
            phase_q <= PH_ADR_LO;
          end
          PH_ADR_LO: begin
            if (is_wr_q) begin
              addr_q  <= full_addr[ADDR_W-1:0];
              phase_q <= PH_WR_DATA;
            end else begin
              addr_q    <= full_addr[ADDR_W-1:0] + 1'b1;
              tx_next_q <= mem_rdata;
              tx_load_q <= 1'b1;
              phase_q   <= PH_RD_DATA;
            end
          end
          PH_RD_DATA: begin
            tx_next_q <= mem_rdata;
            tx_load_q <= 1'b1;
            addr_q    <= addr_q + 1'b1;
          end
          PH_WR_DATA: begin
            addr_q     <= addr_q + 1'b1;
            clr_pend_q <= 1'b1;
          end
          PH_SR_OUT: begin
            tx_next_q <= status_byte;
            tx_load_q <= 1'b1;
          end
          PH_SR_IN: begin
            if (wel_q && !sr_locked) begin
              wpen_q <= byte_in[7];
              bp_q   <= byte_in[3:2];
            end
            clr_pend_q <= 1'b1;
            phase_q    <= PH_VOID;
          end
          default: ;
        endcase
      end
      if (tx_edge) begin
        if (tx_load_q) begin
          tx_sh_q   <= tx_next_q;
          tx_load_q <= 1'b0;
        end else begin
          tx_sh_q <= {tx_sh_q[6:0], 1'b0};
        end
      end
    end
  end

  AST_DESELECT_FRAME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_sel |=> bit_q == 3'd0); // R9

  AST_HOLD_FREEZES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel && !hold_ok) |=> ($stable(bit_q) && $stable(phase_q) && $stable(tx_sh_q))); // R8

  AST_WEN_DROPS_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && clr_pend_q) |=> !wel_q); // R5

  AST_PIN_LOCKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_ok && wpen_q) |=> ($stable(bp_q) && $stable(wpen_q))); // R7

  AST_NO_OUTPUT_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_sel |=> !so_oe); // R9

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_hold_n,
  input  logic spi_wp_n,
  input  logic spi_si,
  output logic spi_so,
  output logic spi_so_oe
);
  logic              sck_rise, sck_fall, cs_sel, cs_rise, hold_ok, wp_ok, si_s;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [7:0]        mem_wdata, mem_rdata;

  smem_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (spi_sck),
    .cs_n     (spi_cs_n),
    .hold_n   (spi_hold_n),
    .wp_n     (spi_wp_n),
    .si       (spi_si),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_sel   (cs_sel),
    .cs_rise  (cs_rise),
    .hold_ok  (hold_ok),
    .wp_ok    (wp_ok),
    .si_s     (si_s)
  );

  smem_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .cs_sel    (cs_sel),
    .cs_rise   (cs_rise),
    .hold_ok   (hold_ok),
    .wp_ok     (wp_ok),
    .si_s      (si_s),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .mem_raddr (mem_raddr),
    .so        (spi_so),
    .so_oe     (spi_so_oe)
  );

  smem_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

endmodule

// File: tb/serial_mem_slave_test.sv
module serial_mem_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HP         = 6;
  localparam int AW         = 10;
  localparam int DEPTH      = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic sck = 0, cs_n = 1, hold_n = 1, wp_n = 1, si = 0;
  logic spi_so, spi_so_oe;

  int checks = 0, errors = 0;
  logic [7:0] ref_mem [DEPTH];
  bit         known   [DEPTH];
  logic       r_wel = 0, r_wpen = 0;
  logic [1:0] r_bp = 0;
  logic [7:0] wbuf [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_mem_slave #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_hold_n(hold_n), .spi_wp_n(wp_n), .spi_si(si),
    .spi_so(spi_so), .spi_so_oe(spi_so_oe));

  function automatic logic [7:0] exp_sr();
    return {r_wpen, 3'b000, r_bp, r_wel, 1'b0};
  endfunction

  function automatic bit is_guarded(int a);
    case (r_bp)
      2'd1:    return a >= (3 * DEPTH) / 4;
      2'd2:    return a >= DEPTH / 2;
      2'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (HP) @(negedge clk);
  endtask

  task automatic sel(bit m3);
    sck = m3; half(); cs_n = 0; half();
  endtask

  task automatic desel(bit m3);
    if (!m3) sck = 0;
    half(); cs_n = 1; half(); half();
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int hold_after = -1);
    for (int i = 7; i >= 0; i--) begin
      sck = 0; si = tx[i]; half();
      rx[i] = spi_so; sck = 1; half();
      if (i == hold_after) begin
        hold_n = 0; half();
        chk("R8 oe during hold", {7'd0, spi_so_oe}, 8'd0);
        sck = 0; si = ~si; half();
        sck = 1; si = 1'($urandom); half();
        hold_n = 1; half();
      end
    end
  endtask

  task automatic send(logic [7:0] tx);
    logic [7:0] d;
    xfer(tx, d);
  endtask

  task automatic one_cmd(bit m3, logic [7:0] op);
    sel(m3); send(op); desel(m3);
  endtask

  task automatic wren(bit m3);
    one_cmd(m3, 8'h06); r_wel = 1;
  endtask

  task automatic sr_check(bit m3, string req);
    logic [7:0] d;
    sel(m3); send(8'h05);
    xfer(8'h00, d); chk(req, d, exp_sr());
    xfer(8'h00, d); chk(req, d, exp_sr());
    desel(m3);
  endtask

  task automatic sr_write(bit m3, logic [7:0] v);
    sel(m3); send(8'h01); send(v); desel(m3);
    if (r_wel && !(r_wpen && !wp_n)) begin
      r_wpen = v[7]; r_bp = v[3:2];
    end
    r_wel = 0;
  endtask

  task automatic mem_write(bit m3, logic [15:0] adr, int n, int hold_after = -1);
    logic [7:0] d;
    sel(m3); send(8'h02); send(adr[15:8]); send(adr[7:0]);
    for (int k = 0; k < n; k++) begin
      int a;
      a = (int'(adr) + k) % DEPTH;
      xfer(wbuf[k], d, (k == 0) ? hold_after : -1);
      if (r_wel && !is_guarded(a)) begin
        ref_mem[a] = wbuf[k]; known[a] = 1;
      end
    end
    desel(m3);
    if (n > 0) r_wel = 0;
  endtask

  task automatic mem_read(bit m3, logic [15:0] adr, int n, string req, int hold_after = -1);
    logic [7:0] d;
    sel(m3); send(8'h03); send(adr[15:8]); send(adr[7:0]);
    for (int k = 0; k < n; k++) begin
      int a;
      a = (int'(adr) + k) % DEPTH;
      xfer(8'h00, d, (k == 0) ? hold_after : -1);
      if (known[a]) chk(req, d, ref_mem[a]);
    end
    desel(m3);
  endtask

  initial begin
    repeat (200000 - 10000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED_2024));
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 oe after reset", {7'd0, spi_so_oe}, 8'd0);
    sr_check(0, "R1 R11 status after reset");

    // R2 R4 R5 basic write, enable flag, read back
    wren(0);
    sr_check(0, "R4 R11 flag set");
    wbuf[0] = 8'h3C; mem_write(0, 16'h0010, 1);
    sr_check(0, "R5 flag cleared after write");
    mem_read(0, 16'h0010, 1, "R2 mode0 readback");
    wbuf[0] = 8'hA5; mem_write(0, 16'h0010, 1);
    mem_read(0, 16'h0010, 1, "R4 write without flag");
    wren(1); one_cmd(1, 8'h04); r_wel = 0;
    wbuf[0] = 8'h77; mem_write(1, 16'h0010, 1);
    mem_read(1, 16'h0010, 1, "R4 flag cleared by command");

    // R2 mode 3, upper address bits ignored
    wren(1);
    for (int k = 0; k < 4; k++) wbuf[k] = 8'(8'h90 + k * 8'h11);
    mem_write(1, 16'hFC20, 4);
    mem_read(1, 16'h0020, 4, "R2 mode3 high bits ignored");
    mem_read(0, 16'h0022, 2, "R12 read right after write");

    // R3 wrap
    wren(0);
    for (int k = 0; k < 4; k++) wbuf[k] = 8'(8'hC1 + k);
    mem_write(0, 16'(DEPTH - 2), 4);
    mem_read(0, 16'(DEPTH - 1), 3, "R3 counter wrap");

    // R6 block protect
    for (int q = 0; q < 4; q++) begin
      wren(0); wbuf[0] = 8'(8'h10 + q);
      mem_write(0, 16'(q * DEPTH / 4 + 5), 1);
    end
    for (int b = 1; b < 4; b++) begin
      wren(0); sr_write(0, 8'(b << 2));
      sr_check(0, "R6 R11 protect field");
      for (int q = 0; q < 4; q++) begin
        wren(1); wbuf[0] = 8'(8'h40 + b * 16 + q);
        mem_write(1, 16'(q * DEPTH / 4 + 5), 1);
        mem_read(1, 16'(q * DEPTH / 4 + 5), 1, "R6 guarded region");
      end
    end
    wren(0); sr_write(0, 8'h00);

    // R7 protect pin
    wren(0); sr_write(0, 8'h84);
    sr_check(0, "R7 arm accepted");
    wp_n = 0;
    wren(0); sr_write(0, 8'h00);
    sr_check(0, "R7 pin locks status");
    wp_n = 1;
    wren(0); sr_write(0, 8'h00);
    sr_check(0, "R7 unlocked write");

    // R8 hold mid-byte
    wren(0); wbuf[0] = 8'h5A; wbuf[1] = 8'hE7;
    mem_write(0, 16'h0100, 2, 4);
    mem_read(0, 16'h0100, 2, "R8 hold during write mode0");
    wren(1); wbuf[0] = 8'h81; wbuf[1] = 8'h18;
    mem_write(1, 16'h0104, 2, 2);
    mem_read(1, 16'h0104, 2, "R8 hold during read mode3", 3);

    // R10 unknown command voids frame
    wren(0);
    sel(0); send(8'hAB); send(8'h02); send(8'h01); send(8'h00);
    xfer(8'hFF, d);
    chk("R10 oe after unknown cmd", {7'd0, spi_so_oe}, 8'd0);
    desel(0);
    mem_read(0, 16'h0100, 1, "R10 array untouched");
    sr_check(0, "R10 flag untouched");

    // R9 deselected activity ignored, partial byte discarded
    for (int i = 0; i < 24; i++) begin
      sck = ~sck; si = 1'($urandom); repeat (3) @(negedge clk);
    end
    sr_check(0, "R9 deselected ignored");
    one_cmd(0, 8'h04); r_wel = 0;
    sel(0);
    for (int i = 7; i >= 4; i--) begin
      sck = 0; si = 1'(8'h06 >> i); half(); sck = 1; half();
    end
    desel(0);
    sr_check(0, "R9 partial command discarded");

    // R9 final edge coincides with release
    wren(0);
    sel(0); send(8'h02); send(8'h01); send(8'h00);
    for (int i = 7; i >= 1; i--) begin
      sck = 0; si = 1'(8'h3F >> i); half(); sck = 1; half();
    end
    sck = 0; si = 1'b1; half();
    sck = 1; cs_n = 1; half(); half();
    mem_read(0, 16'h0100, 1, "R9 cut byte not written");
    sr_check(0, "R9 flag kept after cut byte");
    one_cmd(0, 8'h04); r_wel = 0;

    // random frames
    for (int it = 0; it < 30; it++) begin
      bit m3;
      int n;
      logic [15:0] adr;
      m3 = 1'($urandom);
      n = 1 + int'($urandom % 4);
      adr = 16'($urandom);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      if (it % 10 == 5) begin
        wren(m3); sr_write(m3, {4'b0000, 2'($urandom), 2'b00});
      end
      if (($urandom % 4) != 0) wren(m3);
      mem_write(m3, adr, n);
      mem_read(!m3, adr, n, "R2 R3 R4 R6 random");
    end
    wren(0); sr_write(0, 8'h00);
    sr_check(1, "R11 R12 final status");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule